// File: doc/BRIEF.md
# Write-Protect Register Controller

This block holds the protection state of a serial memory slave. The slave's front end passes it every decoded control byte, the level of the write-protect pin, the three address straps and a flag that marks strap A0 as driven to the high-voltage level. From these inputs the block keeps two software flags. One is a one-time permanent flag. The other is a reversible flag that high-voltage strap commands set and clear. Combined with the pin level, the flags decide which word addresses may be written.

For every control byte in the protect-register family, the block reports in the same cycle whether the byte should be acknowledged. It tracks an accepted command up to the stop condition and then runs that command's own write cycle. It changes a flag only when that cycle completes. A separate combinational port answers whether a given word address is writable at the moment.

Both flags model nonvolatile storage. The reset input returns only the command sequencer and the cycle timer to idle. It never alters a flag.

Top module: `wp_guard`

## Requirements
- R1: `addrWritable` is 0 for every address while `wpPin` is 1. While `wpPin` is 0, an address whose most significant bit is 0 (the lower half, 00h-7Fh) is writable only when both software flags are clear, and an address whose most significant bit is 1 is always writable.
- R2: With `strapA0Hv` low, the byte `0110 b3 b2 b1 0` is the permanent-protect command when bits 3:1 equal `strapA[2:1:0]`. It is acknowledged when `wpPin` is 0 and the permanent flag is clear, and after stop and the write cycle it sets the permanent flag.
- R3: Once the permanent flag is set, no byte whose upper nibble is 0110 is acknowledged, and the flag never clears, including across `rstN`.
- R4: With `strapA0Hv` high and `strapA[2]`=0, `strapA[1]`=0, the byte 62h is acknowledged and, after its write cycle, sets the reversible flag.
- R5: With `strapA0Hv` high, `strapA[2]`=0 and `strapA[1]`=1, the byte 66h is acknowledged and, after its write cycle, clears the reversible flag.
- R6: While `wpPin` is 1, no programming command is acknowledged. A command already accepted is discarded at stop if the pin is then high, so no flag changes.
- R7: `ctrlAck` is combinational and is high only while `ctrlValid` is high with a byte that exactly matches R2, R4 or R5 under the current straps. All other bytes are not acknowledged.
- R8: Stop after an accepted command raises `busy` for exactly `WR_CYCLES` cycles. The flag takes its new value in the cycle `busy` falls, and `ctrlAck` stays 0 while `busy` is high.
- R9: A start condition, or another control byte, arriving before stop cancels the accepted command. A later stop then starts no cycle and changes no flag.
- R10: `rstN` clears `busy` and any accepted command and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of sequencer and timer |
| ctrlValid | input | 1 | A control byte is presented this cycle |
| ctrlByte | input | 8 | Decoded control byte |
| strapA | input | 3 | Address strap levels, bit 0 is A0 |
| strapA0Hv | input | 1 | Strap A0 sits at the high-voltage level |
| wpPin | input | 1 | Write-protect pin level (floating counted as 0) |
| startSeen | input | 1 | Start condition pulse |
| stopSeen | input | 1 | Stop condition pulse closing a write |
| chkAddr | input | ADDR_W | Word address to test |
| ctrlAck | output | 1 | Acknowledge the presented control byte |
| busy | output | 1 | Protect-register write cycle in progress |
| addrWritable | output | 1 | `chkAddr` may be written |

## Verification
The assertions assume single-cycle pulses on `ctrlValid`, `startSeen` and `stopSeen`. They also assume the front end asserts at most one of the three in any cycle, and that the straps and the high-voltage flag are stable while a byte is presented. The bench drives each pulse alone on a falling edge and holds the straps constant through every sweep. It changes `wpPin` only between commands, apart from the single case in R6 where the pin rises between acceptance and stop.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_PERM,
    CMD_REV_SET,
    CMD_REV_CLR
  } cmdKind_t;

  typedef struct packed {
    logic arm;     // latch decoded command as pending
    logic drop;    // forget pending command
    logic launch;  // load write-cycle timer
    logic tick;    // count timer down
    logic commit;  // apply pending command to the flags
  } strobe_t;

  localparam logic [3:0] FAMILY_NIBBLE = 4'b0110;
  localparam logic [7:0] REV_SET_BYTE  = 8'h62;
  localparam logic [7:0] REV_CLR_BYTE  = 8'h66;
endpackage

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ctrlValid,
  input  logic     startSeen,
  input  logic     stopSeen,
  input  cmdKind_t kindIn,
  input  logic     wpPin,
  input  logic     permFlag,
  input  logic     timerZero,
  output strobe_t  stb,
  output logic     busy,
  output logic     ctrlAck
);
  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_CYCLE} state_t;
  state_t state, stateNxt;

  logic accept;
  assign accept  = (kindIn != CMD_NONE) && !wpPin && !permFlag;
  assign busy    = (state == S_CYCLE);
  assign ctrlAck = ctrlValid && accept && !busy;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE, S_ARMED: begin
        if (ctrlValid) begin
          if (accept) begin
            stb.arm  = 1'b1;
            stateNxt = S_ARMED;
          end else begin
            stb.drop = 1'b1;
            stateNxt = S_IDLE;
          end
        end else if (state == S_ARMED && startSeen) begin
          stb.drop = 1'b1;
          stateNxt = S_IDLE;
        end else if (state == S_ARMED && stopSeen) begin
          if (wpPin) begin
            stb.drop = 1'b1;
            stateNxt = S_IDLE;
          end else begin
            stb.launch = 1'b1;
            stateNxt   = S_CYCLE;
          end
        end
      end
      S_CYCLE: begin
        if (timerZero) begin
          stb.commit = 1'b1;
          stateNxt   = S_IDLE;
        end else begin
          stb.tick = 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/wp_dp.sv
module wp_dp
  import wp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        ctrlByte,
  input  logic [2:0]        strapA,
  input  logic              strapA0Hv,
  input  logic              wpPin,
  input  logic [ADDR_W-1:0] chkAddr,
  output cmdKind_t          kindOut,
  output logic              timerZero,
  output logic              permFlag,
  output logic              revFlag,
  output logic              addrWritable
);
  localparam int TW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [TW-1:0] TIMER_LOAD = TW'(WR_CYCLES - 1);

  cmdKind_t      pending;
  logic [TW-1:0] timer;

  // Decode the protect-register family against the straps.
  always_comb begin
    kindOut = CMD_NONE;
    if (strapA0Hv) begin
      if (ctrlByte == REV_SET_BYTE && strapA[2:1] == 2'b00)
        kindOut = CMD_REV_SET;
      else if (ctrlByte == REV_CLR_BYTE && strapA[2:1] == 2'b01)
        kindOut = CMD_REV_CLR;
    end else if (ctrlByte[7:4] == FAMILY_NIBBLE &&
                 ctrlByte[3:1] == strapA && !ctrlByte[0]) begin
      kindOut = CMD_PERM;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= CMD_NONE;
      timer   <= '0;
    end else begin
      if (stb.arm)                      pending <= kindOut;
      else if (stb.drop || stb.commit)  pending <= CMD_NONE;
      if (stb.launch)    timer <= TIMER_LOAD;
      else if (stb.tick) timer <= timer - 1'b1;
    end
  end

  assign timerZero = (timer == '0);

  // Nonvolatile flags: power-on value only, untouched by rstN.
  logic permQ = 1'b0;
  logic revQ  = 1'b0;

  always_ff @(posedge clk) begin
    if (stb.commit) begin
      unique case (pending)
        CMD_PERM:    permQ <= 1'b1;
        CMD_REV_SET: revQ  <= 1'b1;
        CMD_REV_CLR: revQ  <= 1'b0;
        default:     ;
      endcase
    end
  end

  assign permFlag = permQ;
  assign revFlag  = revQ;

  logic lowerHalf;
  assign lowerHalf    = !chkAddr[ADDR_W-1];
  assign addrWritable = !wpPin && !((permQ || revQ) && lowerHalf);
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlValid,
  input  logic [7:0]        ctrlByte,
  input  logic [2:0]        strapA,
  input  logic              strapA0Hv,
  input  logic              wpPin,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic              ctrlAck,
  output logic              busy,
  output logic              addrWritable
);
  strobe_t  stb;
  cmdKind_t kind;
  logic     timerZero;
  logic     permFlag;
  logic     revFlag;

  wp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlValid(ctrlValid), .startSeen(startSeen),
    .stopSeen(stopSeen), .kindIn(kind), .wpPin(wpPin), .permFlag(permFlag),
    .timerZero(timerZero), .stb(stb), .busy(busy), .ctrlAck(ctrlAck)
  );

  wp_dp #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctrlByte(ctrlByte), .strapA(strapA),
    .strapA0Hv(strapA0Hv), .wpPin(wpPin), .chkAddr(chkAddr), .kindOut(kind),
    .timerZero(timerZero), .permFlag(permFlag), .revFlag(revFlag),
    .addrWritable(addrWritable)
  );
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlValid,
  input logic [7:0] ctrlByte,
  input logic       wpPin,
  input logic       ctrlAck,
  input logic       busy,
  input logic       addrWritable,
  input logic       permFlag,
  input logic       revFlag
);
  a_r1_pin_locks_all: assert property (@(posedge clk) disable iff (!rstN)
    wpPin |-> !addrWritable);

  a_r1_open_when_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!wpPin && !permFlag && !revFlag) |-> addrWritable);

  a_r3_perm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    permFlag |=> permFlag);

  a_r3_perm_family_nack: assert property (@(posedge clk) disable iff (!rstN)
    (permFlag && ctrlValid && ctrlByte[7:4] == 4'b0110) |-> !ctrlAck);

  a_r6_pin_nack: assert property (@(posedge clk) disable iff (!rstN)
    (wpPin && ctrlValid) |-> !ctrlAck);

  a_r8_busy_nack: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctrlAck);

  a_r8_rev_at_cycle_end: assert property (@(posedge clk) disable iff (!rstN)
    (revFlag != $past(revFlag)) |-> $past(busy));

  a_r8_perm_at_cycle_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(permFlag) |-> $past(busy));
endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlValid(ctrlValid), .ctrlByte(ctrlByte),
  .wpPin(wpPin), .ctrlAck(ctrlAck), .busy(busy), .addrWritable(addrWritable),
  .permFlag(permFlag), .revFlag(revFlag)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;
  localparam int ADDR_W = 8;
  localparam int WR_CYCLES = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlValid = 1'b0;
  logic [7:0] ctrlByte = 8'h00;
  logic [2:0] strapA = 3'b000;
  logic strapA0Hv = 1'b0;
  logic wpPin = 1'b0;
  logic startSeen = 1'b0;
  logic stopSeen = 1'b0;
  logic [ADDR_W-1:0] chkAddr = '0;
  logic ctrlAck, busy, addrWritable;

  int checks = 0;
  int failures = 0;
  logic mdlProt = 1'b0;  // expected software protection (perm | rev)
  logic mdlPerm = 1'b0;

  always #4 clk = ~clk;

  wp_guard #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) i_wp_guard (
    .clk(clk), .rstN(rstN), .ctrlValid(ctrlValid), .ctrlByte(ctrlByte),
    .strapA(strapA), .strapA0Hv(strapA0Hv), .wpPin(wpPin),
    .startSeen(startSeen), .stopSeen(stopSeen), .chkAddr(chkAddr),
    .ctrlAck(ctrlAck), .busy(busy), .addrWritable(addrWritable)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic modelAck(input logic [7:0] b, input logic [2:0] s,
                                    input logic hv, input logic pin, input logic perm);
    logic match;
    if (hv)
      match = (b == 8'h62 && s[2:1] == 2'b00) || (b == 8'h66 && s[2:1] == 2'b01);
    else
      match = (b[7:4] == 4'b0110) && (b[3:1] == s) && !b[0];
    return match && !pin && !perm;
  endfunction

  task automatic addrSweep(input string req, input logic pin);
    wpPin = pin;
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      chkAddr = ADDR_W'(a);
      #1;
      check(req, addrWritable,
            (!pin && !(mdlProt && a < (1 << (ADDR_W - 1)))) ? 1 : 0);
    end
    wpPin = 1'b0;
  endtask

  task automatic ackSweep(input string req, input logic pin, input logic [2:0] s,
                          input logic hv);
    wpPin = pin; strapA = s; strapA0Hv = hv;
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      ctrlValid = 1'b1; ctrlByte = 8'(b);
      #1;
      check(req, ctrlAck, modelAck(8'(b), s, hv, pin, mdlPerm) ? 1 : 0);
    end
    @(negedge clk); ctrlValid = 1'b0; startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0; wpPin = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    @(negedge clk);
    ctrlValid = 1'b1; ctrlByte = b;
    #1 ack = ctrlAck;
    @(negedge clk);
    ctrlValid = 1'b0;
  endtask

  // Issues stop and returns the number of cycles busy stays high.
  task automatic stopAndWait(output int cyc);
    logic ackInCycle;
    stopSeen = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
    cyc = 0;
    if (busy) begin
      ctrlValid = 1'b1; ctrlByte = 8'h62;
      #1 ackInCycle = ctrlAck;
      check("R8 ack during cycle", ackInCycle, 0);
      #1 ctrlValid = 1'b0;
    end
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset busy", busy, 0);
    check("R7 reset ack", ctrlAck, 0);

    addrSweep("R1 open array", 1'b0);
    addrSweep("R1 pin locks", 1'b1);
    ackSweep("R6 pin high nack", 1'b1, 3'b000, 1'b1);
    ackSweep("R7 decode hv s000", 1'b0, 3'b000, 1'b1);
    ackSweep("R7 decode hv s010", 1'b0, 3'b010, 1'b1);
    ackSweep("R7 decode s101", 1'b0, 3'b101, 1'b0);
    ackSweep("R7 decode hv s110", 1'b0, 3'b110, 1'b1);
    addrSweep("R9 sweeps leave flags", 1'b0);

    // R4: reversible set
    strapA = 3'b000; strapA0Hv = 1'b1;
    sendByte(8'h62, ack);
    check("R4 set ack", ack, 1);
    stopAndWait(cyc);
    check("R8 cycle length", cyc, WR_CYCLES);
    mdlProt = 1'b1;
    addrSweep("R4 lower protected", 1'b0);

    // R9: abandon by start then by another byte
    strapA = 3'b010;
    sendByte(8'h66, ack);
    check("R5 clear ack", ack, 1);
    @(negedge clk); startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0;
    stopAndWait(cyc);
    check("R9 no cycle after start", cyc, 0);
    sendByte(8'h66, ack);
    sendByte(8'h00, ack);
    stopAndWait(cyc);
    check("R9 no cycle after other byte", cyc, 0);
    addrSweep("R9 flag kept", 1'b0);

    // R6: pin high at command, then pin rising before stop
    wpPin = 1'b1;
    sendByte(8'h66, ack);
    check("R6 nack pin high", ack, 0);
    stopAndWait(cyc);
    check("R6 no cycle", cyc, 0);
    wpPin = 1'b0;
    sendByte(8'h66, ack);
    check("R6 ack pin low", ack, 1);
    wpPin = 1'b1;
    stopAndWait(cyc);
    check("R6 dropped at stop", cyc, 0);
    wpPin = 1'b0;
    addrSweep("R6 flag kept", 1'b0);

    // R5: proper clear
    sendByte(8'h66, ack);
    stopAndWait(cyc);
    check("R5 cycle", cyc, WR_CYCLES);
    mdlProt = 1'b0;
    addrSweep("R5 lower open", 1'b0);

    // R2: permanent set, straps 101 -> byte 0110_101_0
    strapA = 3'b101; strapA0Hv = 1'b0;
    sendByte(8'h6A, ack);
    check("R2 perm ack", ack, 1);
    stopAndWait(cyc);
    check("R2 cycle", cyc, WR_CYCLES);
    mdlProt = 1'b1; mdlPerm = 1'b1;
    addrSweep("R2 lower protected", 1'b0);

    // R3: family nacked, no clearing
    strapA = 3'b010; strapA0Hv = 1'b1;
    sendByte(8'h66, ack);
    check("R3 clear nack", ack, 0);
    stopAndWait(cyc);
    check("R3 no cycle", cyc, 0);
    ackSweep("R3 family nack", 1'b0, 3'b101, 1'b0);
    ackSweep("R3 family nack hv", 1'b0, 3'b000, 1'b1);

    // R10: reset keeps flags
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R10 busy after reset", busy, 0);
    addrSweep("R10 R3 flags survive reset", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule